// File: doc/BRIEF.md
# Unified-Index Physical Register File

This block stores the renamed operand values of an out-of-order core. An integer bank and a floating-point bank share one physical index space. Indices below `NUM_INT` select the integer bank. Indices from `NUM_INT` up to `NUM_INT+NUM_FP-1` select the floating bank, at local entry `index - NUM_INT`. Floating data is held as an opaque 64-bit pattern, so reading it as a value or as raw bits gives the same result. Each hardware thread also has its own small bank of miscellaneous registers, chosen by a thread ID.

There are two registered read ports and one write port. A 2-bit kind selects the write target and its rules: integer, floating value, floating raw bits, or miscellaneous. The integer zero-register entry can never be written. A floating *value* write to the local zero entry is dropped when `FP_ZERO_SUPPRESS` is set. A floating *raw-bits* write is always performed. Any enabled access with an index outside its bank is dropped and raises a one-cycle error flag.

Top module: `phys_regfile`

## Requirements
- R1: After reset, every integer, floating and miscellaneous entry reads zero, both read data outputs are zero and `err_o` is low.
- R2: A write of kind integer (`wr_kind`=0) to index i < NUM_INT is returned by a physical read (`rdN_misc`=0) of i. A floating write (kind 1 or 2) to index j with NUM_INT <= j < NUM_INT+NUM_FP lands in floating entry j-NUM_INT and is returned by a physical read of j.
- R3: An integer write to index ZERO_IDX is discarded, and that index keeps reading zero.
- R4: With FP_ZERO_SUPPRESS=1, a floating value write (kind 1) to physical index NUM_INT+ZERO_IDX is discarded without an error.
- R5: A floating raw-bits write (kind 2) to physical index NUM_INT+ZERO_IDX is always stored.
- R6: Value writes (kind 1) and raw-bits writes (kind 2) to a non-zero floating entry store the 64-bit pattern unchanged, and a read returns it bit for bit.
- R7: An integer write with index >= NUM_INT changes no entry. It sets `err_o` in the next cycle.
- R8: A floating write with index < NUM_INT or index >= NUM_INT+NUM_FP changes no entry. It sets `err_o` in the next cycle.
- R9: A read returns its data one cycle after the request. A read in the same cycle as a write to the same entry returns the old value. A port that is not enabled holds its output.
- R10: A miscellaneous write (kind 3) with `wr_idx` < NUM_MISC goes to the bank of thread `thr_i`. A read with `rdN_misc`=1 returns entry `rdN_idx` of thread `thr_i`'s bank. Threads do not share entries. A misc index >= NUM_MISC is dropped and flagged.
- R11: An enabled read whose index is outside its bank returns zero and sets `err_o` in the next cycle.
- R12: `err_o` is high only in the cycle after at least one enabled out-of-range access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all banks |
| thr_i | input | TID_W | Thread selecting the miscellaneous bank for reads and writes |
| rd0_en | input | 1 | Read port 0 request |
| rd0_misc | input | 1 | Port 0: 1 = miscellaneous bank, 0 = physical index space |
| rd0_idx | input | IDX_W | Port 0 index |
| rd0_data | output | DW | Port 0 data, one cycle after request |
| rd1_en | input | 1 | Read port 1 request |
| rd1_misc | input | 1 | Port 1: 1 = miscellaneous bank, 0 = physical index space |
| rd1_idx | input | IDX_W | Port 1 index |
| rd1_data | output | DW | Port 1 data, one cycle after request |
| wr_en | input | 1 | Write request |
| wr_kind | input | 2 | 0 integer, 1 floating value, 2 floating raw bits, 3 miscellaneous |
| wr_idx | input | IDX_W | Write index |
| wr_data | input | DW | Write data |
| err_o | output | 1 | Out-of-range access seen in the previous cycle |

## Verification
The bench targets the seam between the banks at NUM_INT and the two zero-entry rules.

- A design that forgets the offset writes floating data into the integer bank, so a later integer read returns the floating data.
- A design that treats both floating write kinds the same either loses the raw-bits write at the zero entry or keeps the value write there.
- A write-to-read bypass shows up as new data in the same-cycle read.
- A missing range check shows up as a corrupted neighbour entry or a silent `err_o`.
- A long random run mixes all four write kinds with both read ports. It compares every output each cycle against a behavioural model.

// File: rtl/prf_pkg.sv
package prf_pkg;

    typedef enum logic [1:0] {
        WK_INT     = 2'd0,
        WK_FP_VAL  = 2'd1,
        WK_FP_RAW  = 2'd2,
        WK_MISC    = 2'd3
    } wr_kind_e;

    typedef struct packed {
        logic int_we;
        logic fp_we;
        logic misc_we;
        logic err;
    } wr_dec_t;

    function automatic int unsigned addr_w(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/prf_bank.sv
module prf_bank #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 64,
    parameter int unsigned NRD   = 2,
    localparam int unsigned AW   = prf_pkg::addr_w(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= '0;
            end
        end else if (we && (32'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < int'(NRD); p++) begin : g_rport
        assign rdata[p] = (32'(raddr[p]) < DEPTH) ? mem[raddr[p]] : '0;
    end

endmodule

// File: rtl/prf_misc_bank.sv
module prf_misc_bank #(
    parameter int unsigned NUM_THREADS = 2,
    parameter int unsigned NUM_MISC    = 8,
    parameter int unsigned DW          = 64,
    parameter int unsigned NRD         = 2,
    localparam int unsigned TID_W      = prf_pkg::addr_w(NUM_THREADS),
    localparam int unsigned MA         = prf_pkg::addr_w(NUM_MISC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [TID_W-1:0]         thr,
    input  logic [MA-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][MA-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);

    logic [NRD-1:0][DW-1:0] per_thr [NUM_THREADS];

    // One private bank per hardware thread
    for (genvar t = 0; t < int'(NUM_THREADS); t++) begin : g_thr
        prf_bank #(.DEPTH(NUM_MISC), .DW(DW), .NRD(NRD)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (we && (32'(thr) == t)),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (raddr),
            .rdata (per_thr[t])
        );
    end

    for (genvar p = 0; p < int'(NRD); p++) begin : g_sel
        assign rdata[p] = (32'(thr) < NUM_THREADS) ? per_thr[thr][p] : '0;
    end

endmodule

// File: rtl/prf_wr_decode.sv
module prf_wr_decode
    import prf_pkg::*;
#(
    parameter int unsigned NUM_INT          = 40,
    parameter int unsigned NUM_FP           = 40,
    parameter int unsigned NUM_MISC         = 8,
    parameter int unsigned NUM_THREADS      = 2,
    parameter int unsigned ZERO_IDX         = 0,
    parameter bit          FP_ZERO_SUPPRESS = 1'b1,
    parameter int unsigned IDX_W            = 7,
    parameter int unsigned TID_W            = 1
) (
    input  logic              wr_en,
    input  wr_kind_e          kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TID_W-1:0]  thr,
    output wr_dec_t           dec,
    output logic [31:0]       idx_wide,
    output logic [31:0]       fp_loc
);

    localparam int unsigned TOTAL = NUM_INT + NUM_FP;

    always_comb begin
        idx_wide = 32'(idx);
        fp_loc   = idx_wide - NUM_INT;
        dec      = '0;
        if (wr_en) begin
            case (kind)
                WK_INT: begin
                    if (idx_wide >= NUM_INT) dec.err = 1'b1;
                    else                     dec.int_we = (idx_wide != ZERO_IDX);
                end
                WK_FP_VAL, WK_FP_RAW: begin
                    if (idx_wide < NUM_INT || idx_wide >= TOTAL) begin
                        dec.err = 1'b1;
                    end else begin
                        // value writes honour the zero entry, raw-bit writes never do
                        dec.fp_we = !(kind == WK_FP_VAL && FP_ZERO_SUPPRESS
                                      && fp_loc == ZERO_IDX);
                    end
                end
                default: begin
                    if (idx_wide >= NUM_MISC || 32'(thr) >= NUM_THREADS) dec.err = 1'b1;
                    else                                                 dec.misc_we = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/phys_regfile.sv
module phys_regfile
    import prf_pkg::*;
#(
    parameter int unsigned NUM_INT          = 40,
    parameter int unsigned NUM_FP           = 40,
    parameter int unsigned ZERO_IDX         = 0,
    parameter bit          FP_ZERO_SUPPRESS = 1'b1,
    parameter int unsigned NUM_THREADS      = 2,
    parameter int unsigned NUM_MISC         = 8,
    parameter int unsigned DW               = 64,
    localparam int unsigned TOTAL           = NUM_INT + NUM_FP,
    localparam int unsigned IDX_W           = addr_w(TOTAL),
    localparam int unsigned TID_W           = addr_w(NUM_THREADS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TID_W-1:0]  thr_i,
    input  logic              rd0_en,
    input  logic              rd0_misc,
    input  logic [IDX_W-1:0]  rd0_idx,
    output logic [DW-1:0]     rd0_data,
    input  logic              rd1_en,
    input  logic              rd1_misc,
    input  logic [IDX_W-1:0]  rd1_idx,
    output logic [DW-1:0]     rd1_data,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    output logic              err_o
);

    localparam int unsigned NRD = 2;
    localparam int unsigned IA  = addr_w(NUM_INT);
    localparam int unsigned FA  = addr_w(NUM_FP);
    localparam int unsigned MA  = addr_w(NUM_MISC);

    // ---------------- write side ----------------
    wr_dec_t     wdec;
    logic [31:0] w_idx32;
    logic [31:0] w_fp32;

    prf_wr_decode #(
        .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .NUM_MISC(NUM_MISC),
        .NUM_THREADS(NUM_THREADS), .ZERO_IDX(ZERO_IDX),
        .FP_ZERO_SUPPRESS(FP_ZERO_SUPPRESS), .IDX_W(IDX_W), .TID_W(TID_W)
    ) u_wdec (
        .wr_en    (wr_en),
        .kind     (wr_kind_e'(wr_kind)),
        .idx      (wr_idx),
        .thr      (thr_i),
        .dec      (wdec),
        .idx_wide (w_idx32),
        .fp_loc   (w_fp32)
    );

    // ---------------- read side decode ----------------
    logic [NRD-1:0]            rd_en_v;
    logic [NRD-1:0]            rd_misc_v;
    logic [NRD-1:0][IDX_W-1:0] rd_idx_v;
    logic [NRD-1:0][IA-1:0]    int_ra;
    logic [NRD-1:0][FA-1:0]    fp_ra;
    logic [NRD-1:0][MA-1:0]    misc_ra;
    logic [NRD-1:0][DW-1:0]    int_rd;
    logic [NRD-1:0][DW-1:0]    fp_rd;
    logic [NRD-1:0][DW-1:0]    misc_rd;
    logic [NRD-1:0][DW-1:0]    rd_sel;
    logic [NRD-1:0]            rd_bad;
    logic [NRD-1:0][DW-1:0]    rd_q;
    logic                      err_q;

    assign rd_en_v   = {rd1_en, rd0_en};
    assign rd_misc_v = {rd1_misc, rd0_misc};
    assign rd_idx_v  = {rd1_idx, rd0_idx};

    for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
        logic [31:0]   i32;
        logic [31:0]   f32;
        logic          bad;
        logic [DW-1:0] sel;

        assign i32        = 32'(rd_idx_v[p]);
        assign f32        = i32 - NUM_INT;
        assign int_ra[p]  = i32[IA-1:0];
        assign fp_ra[p]   = f32[FA-1:0];
        assign misc_ra[p] = i32[MA-1:0];

        always_comb begin
            bad = 1'b0;
            sel = '0;
            if (rd_misc_v[p]) begin
                if (i32 >= NUM_MISC || 32'(thr_i) >= NUM_THREADS) bad = 1'b1;
                else                                              sel = misc_rd[p];
            end else if (i32 < NUM_INT) begin
                sel = int_rd[p];
            end else if (i32 < TOTAL) begin
                sel = fp_rd[p];
            end else begin
                bad = 1'b1;
            end
        end

        assign rd_sel[p] = sel;
        assign rd_bad[p] = bad;
    end

    // ---------------- storage ----------------
    prf_bank #(.DEPTH(NUM_INT), .DW(DW), .NRD(NRD)) u_int_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (wdec.int_we),
        .waddr (w_idx32[IA-1:0]),
        .wdata (wr_data),
        .raddr (int_ra),
        .rdata (int_rd)
    );

    prf_bank #(.DEPTH(NUM_FP), .DW(DW), .NRD(NRD)) u_fp_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (wdec.fp_we),
        .waddr (w_fp32[FA-1:0]),
        .wdata (wr_data),
        .raddr (fp_ra),
        .rdata (fp_rd)
    );

    prf_misc_bank #(.NUM_THREADS(NUM_THREADS), .NUM_MISC(NUM_MISC),
                    .DW(DW), .NRD(NRD)) u_misc_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (wdec.misc_we),
        .thr   (thr_i),
        .waddr (w_idx32[MA-1:0]),
        .wdata (wr_data),
        .raddr (misc_ra),
        .rdata (misc_rd)
    );

    // ---------------- output registers (no bypass) ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            for (int p = 0; p < int'(NRD); p++) begin
                if (rd_en_v[p]) rd_q[p] <= rd_bad[p] ? '0 : rd_sel[p];
            end
            err_q <= (|(rd_en_v & rd_bad)) | wdec.err;
        end
    end

    assign rd0_data = rd_q[0];
    assign rd1_data = rd_q[1];
    assign err_o    = err_q;

endmodule

// File: rtl/prf_chk.sv
module prf_chk #(
    parameter int unsigned NUM_INT  = 40,
    parameter int unsigned TOTAL    = 80,
    parameter int unsigned ZERO_IDX = 0,
    parameter int unsigned IDX_W    = 7,
    parameter int unsigned DW       = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             rd0_en,
    input logic             rd0_misc,
    input logic [IDX_W-1:0] rd0_idx,
    input logic [DW-1:0]    rd0_data,
    input logic             rd1_en,
    input logic             wr_en,
    input logic [1:0]       wr_kind,
    input logic [IDX_W-1:0] wr_idx,
    input logic             err_o
);

    p_int_oob_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == 2'd0 && 32'(wr_idx) >= NUM_INT) |=> err_o)
        else $error("R7 integer write out of range not flagged");

    p_fp_low_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_kind == 2'd1 || wr_kind == 2'd2) && 32'(wr_idx) < NUM_INT) |=> err_o)
        else $error("R8 floating write below bank not flagged");

    p_zero_int_r3: assert property (@(posedge clk) disable iff (rst)
        (rd0_en && !rd0_misc && 32'(rd0_idx) == ZERO_IDX) |=> (rd0_data == '0))
        else $error("R3 zero register read non-zero");

    p_rd_oob_r11: assert property (@(posedge clk) disable iff (rst)
        (rd0_en && !rd0_misc && 32'(rd0_idx) >= TOTAL) |=> (err_o && rd0_data == '0))
        else $error("R11 out-of-range read not handled");

    p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rd0_en && !rd1_en) |=> !err_o)
        else $error("R12 error flag without access");

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!rd0_en) |=> $stable(rd0_data))
        else $error("R9 idle read port changed");

endmodule

bind phys_regfile prf_chk #(
    .NUM_INT(NUM_INT), .TOTAL(TOTAL), .ZERO_IDX(ZERO_IDX),
    .IDX_W(IDX_W), .DW(DW)
) u_chk (
    .clk(clk), .rst(rst), .rd0_en(rd0_en), .rd0_misc(rd0_misc),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_en(rd1_en),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .err_o(err_o)
);

// File: tb/phys_regfile_tb.sv
module phys_regfile_tb;

    localparam int NI = 40;
    localparam int NF = 40;
    localparam int NT = 2;
    localparam int NM = 8;
    localparam int ZI = 0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [0:0]  thr_i = '0;
    logic        rd0_en = 0, rd0_misc = 0, rd1_en = 0, rd1_misc = 0;
    logic [6:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
    logic [63:0] rd0_data, rd1_data, wr_data = '0;
    logic        wr_en = 0;
    logic [1:0]  wr_kind = '0;
    logic        err_o;

    always #4 clk = ~clk;

    phys_regfile u_dut (
        .clk(clk), .rst(rst), .thr_i(thr_i),
        .rd0_en(rd0_en), .rd0_misc(rd0_misc), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
        .rd1_en(rd1_en), .rd1_misc(rd1_misc), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .err_o(err_o)
    );

    // behavioural model
    logic [63:0] im [NI];
    logic [63:0] fm [NF];
    logic [63:0] mm [NT][NM];
    logic [63:0] exp0 = '0, exp1 = '0;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic void mread(input logic m, input int i, input int th,
                                  output logic [63:0] d, output bit bad);
        d = '0; bad = 0;
        if (m) begin
            if (i >= NM || th >= NT) bad = 1; else d = mm[th][i];
        end else if (i < NI) d = im[i];
        else if (i < NI + NF) d = fm[i - NI];
        else bad = 1;
    endfunction

    function automatic bit mwrite(input int k, input int i, input logic [63:0] d, input int th);
        bit bad = 0;
        case (k)
            0: if (i >= NI) bad = 1; else if (i != ZI) im[i] = d;
            1: if (i < NI || i >= NI + NF) bad = 1; else if ((i - NI) != ZI) fm[i - NI] = d;
            2: if (i < NI || i >= NI + NF) bad = 1; else fm[i - NI] = d;
            default: if (i >= NM || th >= NT) bad = 1; else mm[th][i] = d;
        endcase
        return bad;
    endfunction

    task automatic cyc(input logic r0e, input logic r0m, input int r0i,
                       input logic r1e, input logic r1m, input int r1i,
                       input logic we, input int wk, input int wi,
                       input logic [63:0] wd, input int th, input string tag);
        logic [63:0] d;
        bit b, errx;
        rd0_en = r0e; rd0_misc = r0m; rd0_idx = 7'(r0i);
        rd1_en = r1e; rd1_misc = r1m; rd1_idx = 7'(r1i);
        wr_en = we; wr_kind = 2'(wk); wr_idx = 7'(wi); wr_data = wd; thr_i = 1'(th);
        @(posedge clk);
        errx = 0;
        if (r0e) begin mread(r0m, r0i, th, d, b); exp0 = b ? '0 : d; errx |= b; end
        if (r1e) begin mread(r1m, r1i, th, d, b); exp1 = b ? '0 : d; errx |= b; end
        if (we) errx |= mwrite(wk, wi, wd, th);
        #2;
        chk(tag, "rd0_data", rd0_data, exp0);
        chk(tag, "rd1_data", rd1_data, exp1);
        chk(tag, "err_o", 64'(err_o), 64'(errx));
    endtask

    task automatic rd2(input int a, input int b, input string tag);
        cyc(1, 0, a, 1, 0, b, 0, 0, 0, '0, 0, tag);
    endtask

    task automatic wr(input int k, input int i, input logic [63:0] d, input int th, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, k, i, d, th, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        for (int i = 0; i < NI; i++) im[i] = '0;
        for (int i = 0; i < NF; i++) fm[i] = '0;
        for (int t = 0; t < NT; t++) for (int i = 0; i < NM; i++) mm[t][i] = '0;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1: outputs after reset
        chk("R1", "rd0_data", rd0_data, '0);
        chk("R1", "rd1_data", rd1_data, '0);
        chk("R1", "err_o", 64'(err_o), '0);
        for (int i = 0; i < NI + NF; i += 2) rd2(i, i + 1, "R1");
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < NM; i += 2) cyc(1, 1, i, 1, 1, i + 1, 0, 0, 0, '0, t, "R1");

        // R2: both banks through the shared index space
        wr(0, 5, 64'h1111_2222_3333_4444, 0, "R2");
        wr(2, NI + 5, 64'hAAAA_BBBB_CCCC_DDDD, 0, "R2");
        wr(0, NI - 1, 64'h0123_4567_89AB_CDEF, 0, "R2");
        wr(2, NI + NF - 1, 64'hFEDC_BA98_7654_3210, 0, "R2");
        rd2(5, NI + 5, "R2");
        rd2(NI - 1, NI + NF - 1, "R2");

        // R3: integer zero register
        wr(0, ZI, 64'hDEAD_BEEF_0000_0001, 0, "R3");
        rd2(ZI, ZI, "R3");

        // R4: value write to floating zero entry dropped
        wr(1, NI + ZI, 64'h5555_0000_5555_0000, 0, "R4");
        rd2(NI + ZI, ZI, "R4");

        // R5: raw-bits write to floating zero entry stored
        wr(2, NI + ZI, 64'h7777_8888_9999_AAAA, 0, "R5");
        rd2(NI + ZI, ZI, "R5");

        // R6: value and raw views keep the same pattern
        wr(1, NI + 10, 64'h8000_0000_0000_0001, 0, "R6");
        wr(2, NI + 11, 64'h7FF8_0000_0000_0000, 0, "R6");
        rd2(NI + 10, NI + 11, "R6");

        // R7: integer write beyond integer bank
        wr(0, NI + 5, 64'hBAD0_BAD0_BAD0_BAD0, 0, "R7");
        rd2(NI + 5, 5, "R7");

        // R8: floating writes below the bank and past the end
        wr(1, 5, 64'hBAD1_BAD1_BAD1_BAD1, 0, "R8");
        wr(2, NI + NF + 3, 64'hBAD2_BAD2_BAD2_BAD2, 0, "R8");
        rd2(5, NI + NF - 1, "R8");

        // R9: same-cycle read and write, then hold while idle
        cyc(1, 0, 7, 1, 0, NI + 7, 1, 0, 7, 64'h0000_0000_CAFE_F00D, 0, "R9");
        cyc(1, 0, 7, 0, 0, 0, 1, 2, NI + 7, 64'h1234_0000_0000_5678, 0, "R9");
        cyc(0, 0, 0, 1, 0, NI + 7, 0, 0, 0, '0, 0, "R9");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, '0, 0, "R9");

        // R10: per-thread miscellaneous banks
        wr(3, 2, 64'h0000_0000_0000_00A0, 0, "R10");
        wr(3, 2, 64'h0000_0000_0000_00B1, 1, "R10");
        cyc(1, 1, 2, 1, 0, 2, 0, 0, 0, '0, 0, "R10");
        cyc(1, 1, 2, 1, 1, 3, 0, 0, 0, '0, 1, "R10");
        wr(3, NM + 1, 64'hBAD3, 1, "R10");
        cyc(1, 1, NM + 1, 1, 1, 1, 0, 0, 0, '0, 1, "R10");

        // R11: out-of-range reads
        rd2(NI + NF, 127, "R11");

        // R12 and R2: mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            cyc($urandom_range(0, 1), $urandom_range(0, 3) == 0, $urandom_range(0, 127),
                $urandom_range(0, 1), $urandom_range(0, 3) == 0, $urandom_range(0, 127),
                $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 127),
                {$urandom, $urandom}, $urandom_range(0, NT - 1), "R12");
        end
        summary();
    end

endmodule